// File: doc/BRIEF.md
# Associative Address Translation Buffer with Recency Replacement

This block holds a small set of virtual-to-physical page translations and answers lookups in the same cycle as the request. A requester presents a 32-bit virtual address with a valid flag. If a stored entry covers that page, the block reports a hit, forms the physical address from the entry's frame base and the request's page offset, and returns the entry's non-cacheable attribute. If no entry covers the page, it raises a miss, so that an external walker or software can fetch the translation and write it in through the install port.

All entries share one run-time page size of 512, 1024 or 2048 bytes. Tags always keep virtual bits 31 down to 9; the compare ignores the tag bits that fall inside the offset of the current size, and any change of the size empties the buffer. Entries are replaced in least-recently-used order over the whole set, and are removed either one at a time by address or all at once.

Top module: `xlat_buf`

## Requirements
- R1: The lookup is combinational: with `lk_valid` high, `lk_hit` is high in the same cycle when a valid entry covers `lk_va` under the current page size, and `lk_miss` is high otherwise; with `lk_valid` low both are low.
- R2: On a hit, `lk_pa` is the entry's physical frame base with the low offset bits taken from `lk_va`; `pg_sel` 2'b00 gives a 9-bit offset, 2'b01 a 10-bit offset, 2'b10 an 11-bit offset, and 2'b11 a 9-bit offset.
- R3: `lk_nc` carries the non-cacheable bit of the hit entry and is low on a miss.
- R4: An install (`wr_en`) takes effect at the next clock edge; it overwrites the entry that already covers `wr_va` if there is one, otherwise the lowest-numbered invalid entry, otherwise the least recently used entry.
- R5: A lookup hit with no install in the same cycle, or an install, makes that entry the most recently used; the entry replaced when the buffer is full is the one used longest ago.
- R6: `inv_one` clears the entry that covers `inv_va` at the next edge and leaves every other entry unchanged.
- R7: `inv_all` clears every entry in one cycle and overrides an install in the same cycle.
- R8: A change of `pg_sel` clears every entry at the next edge, and lookups in the cycle of the change miss.
- R9: After reset the buffer holds no valid entry and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_sel | input | 2 | Page-size select |
| lk_valid | input | 1 | Lookup request valid |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_pa | output | 32 | Translated physical address |
| lk_nc | output | 1 | Hit page is non-cacheable |
| wr_en | input | 1 | Install a translation |
| wr_va | input | 32 | Virtual address of the installed page |
| wr_pa | input | 32 | Physical address of the installed frame |
| wr_nc | input | 1 | Non-cacheable bit of the installed page |
| inv_one | input | 1 | Invalidate the entry covering inv_va |
| inv_va | input | 32 | Address for single invalidation |
| inv_all | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default of 16 entries, small enough to fill the buffer completely under every page-size code and to follow every entry's recency in a timestamp model. That brings the full-buffer eviction choice, reuse of a freed slot ahead of the LRU entry, overwriting of an already covered page, and offsets at both ends of each page size within reach of direct checks, including the reserved size code and the flush caused by a size change.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int OFF_MIN = 9;
  localparam int VTAG_W  = VA_W - OFF_MIN;
  localparam int PTAG_W  = PA_W - OFF_MIN;

  typedef logic [1:0] pgsel_t;

  // offset width selected by the page-size code
  function automatic int unsigned off_bits(pgsel_t s);
    case (s)
      2'b01:   return 10;
      2'b10:   return 11;
      default: return 9;
    endcase
  endfunction

  // tag bits that take part in the compare for a page size
  function automatic logic [VTAG_W-1:0] vtag_mask(pgsel_t s);
    logic [VTAG_W-1:0] m;
    m = '1;
    return m << (off_bits(s) - OFF_MIN);
  endfunction

  function automatic logic [VTAG_W-1:0] va_tag(logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_MIN];
  endfunction

  function automatic logic [PTAG_W-1:0] pa_tag(logic [PA_W-1:0] pa);
    return pa[PA_W-1:OFF_MIN];
  endfunction

  function automatic logic tag_eq(logic [VTAG_W-1:0] t, logic [VA_W-1:0] va, pgsel_t s);
    return ((t ^ va_tag(va)) & vtag_mask(s)) == '0;
  endfunction

  // frame base from the entry, page offset from the request
  function automatic logic [PA_W-1:0] compose_pa(logic [PTAG_W-1:0] ptag,
                                                 logic [VA_W-1:0] va, pgsel_t s);
    logic [PA_W-1:0] lowm;
    lowm = (PA_W'(1) << off_bits(s)) - PA_W'(1);
    return ({ptag, {OFF_MIN{1'b0}}} & ~lowm) | (PA_W'(va) & lowm);
  endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pgsel_t                        pg_sel,
  input  logic                          clr_all,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VA_W-1:0]               wr_va,
  input  logic [PA_W-1:0]               wr_pa,
  input  logic                          wr_nc,
  input  logic                          inv_one,
  input  logic [VA_W-1:0]               inv_va,
  input  logic [VA_W-1:0]               lk_va,
  output logic [ENTRIES-1:0]            lk_match,
  output logic [ENTRIES-1:0]            wr_match,
  output logic [ENTRIES-1:0]            inv_match,
  output logic [ENTRIES-1:0]            valid_q,
  output logic [ENTRIES-1:0][PTAG_W-1:0] ptag_q,
  output logic [ENTRIES-1:0]            nc_q
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VTAG_W-1:0] vtag_r;
    logic              wr_sel;
    assign wr_sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        vtag_r     <= '0;
        ptag_q[g]  <= '0;
        nc_q[g]    <= 1'b0;
      end else if (clr_all) begin
        valid_q[g] <= 1'b0;
      end else if (wr_sel) begin
        valid_q[g] <= 1'b1;
        vtag_r     <= va_tag(wr_va);
        ptag_q[g]  <= pa_tag(wr_pa);
        nc_q[g]    <= wr_nc;
      end else if (inv_one && inv_match[g]) begin
        valid_q[g] <= 1'b0;
      end
    end

    assign lk_match[g]  = valid_q[g] && tag_eq(vtag_r, lk_va, pg_sel);
    assign wr_match[g]  = valid_q[g] && tag_eq(vtag_r, wr_va, pg_sel);
    assign inv_match[g] = valid_q[g] && tag_eq(vtag_r, inv_va, pg_sel);
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [IDX_W-1:0]         touch_idx,
  output logic [IDX_W-1:0]         lru_idx,
  output logic [ENTRIES*IDX_W-1:0] ord_flat
);
  // slot 0 holds the most recent index, the last slot the oldest
  logic [IDX_W-1:0] ord_q [ENTRIES];
  logic [IDX_W-1:0] ord_d [ENTRIES];
  int unsigned      pos;

  always_comb begin
    pos = 0;
    for (int p = 0; p < ENTRIES; p++)
      if (ord_q[p] == touch_idx) pos = p;
    for (int k = 0; k < ENTRIES; k++) begin
      if (!touch_en)                 ord_d[k] = ord_q[k];
      else if (k == 0)               ord_d[k] = touch_idx;
      else if (k <= int'(pos))       ord_d[k] = ord_q[k-1];
      else                           ord_d[k] = ord_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) ord_q[k] <= IDX_W'(k);
    end else begin
      for (int k = 0; k < ENTRIES; k++) ord_q[k] <= ord_d[k];
    end
  end

  assign lru_idx = ord_q[ENTRIES-1];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_flat
    assign ord_flat[k*IDX_W +: IDX_W] = ord_q[k];
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pg_sel,
  input  logic        lk_valid,
  input  logic [31:0] lk_va,
  output logic        lk_hit,
  output logic        lk_miss,
  output logic [31:0] lk_pa,
  output logic        lk_nc,
  input  logic        wr_en,
  input  logic [31:0] wr_va,
  input  logic [31:0] wr_pa,
  input  logic        wr_nc,
  input  logic        inv_one,
  input  logic [31:0] inv_va,
  input  logic        inv_all
);
  localparam int IDX_W = $clog2(ENTRIES);

  pgsel_t                         pg_q;
  logic                           pg_chg;
  logic                           clr_all;
  logic [ENTRIES-1:0]             lk_match, wr_match, inv_match, valid_q, nc_q;
  logic [ENTRIES-1:0][PTAG_W-1:0] ptag_q;
  logic [IDX_W-1:0]               hit_idx, wr_idx, lru_idx, touch_idx;
  logic                           hit_any, wr_live, touch_en;
  logic [ENTRIES*IDX_W-1:0]       ord_flat;

  // page-size change flushes the buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 2'b00;
    else        pg_q <= pg_sel;
  end
  assign pg_chg  = (pg_sel != pg_q);
  assign clr_all = inv_all || pg_chg;

  xlat_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
    .clk, .rst_n, .pg_sel, .clr_all,
    .wr_en, .wr_idx, .wr_va, .wr_pa, .wr_nc,
    .inv_one, .inv_va, .lk_va,
    .lk_match, .wr_match, .inv_match, .valid_q, .ptag_q, .nc_q
  );

  // encode the hit entry
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) hit_idx |= IDX_W'(i);
  end

  assign hit_any = (|lk_match) && !pg_chg;
  assign lk_hit  = lk_valid && hit_any;
  assign lk_miss = lk_valid && !hit_any;
  assign lk_pa   = lk_hit ? compose_pa(ptag_q[hit_idx], lk_va, pg_sel) : '0;
  assign lk_nc   = lk_hit && nc_q[hit_idx];

  // install target: covering entry, else lowest invalid, else LRU
  always_comb begin
    wr_idx = lru_idx;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!valid_q[i]) wr_idx = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (wr_match[i]) wr_idx = IDX_W'(i);
  end

  assign wr_live   = wr_en && !clr_all;
  assign touch_en  = wr_live || lk_hit;
  assign touch_idx = wr_live ? wr_idx : hit_idx;

  xlat_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk, .rst_n, .touch_en, .touch_idx, .lru_idx, .ord_flat
  );
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lk_valid,
  input logic                     lk_hit,
  input logic                     lk_miss,
  input logic                     lk_nc,
  input logic [ENTRIES-1:0]       lk_match,
  input logic                     clr_all,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic                     inv_one,
  input logic [ENTRIES-1:0]       inv_match,
  input logic                     touch_en,
  input logic [IDX_W-1:0]         touch_idx,
  input logic [ENTRIES-1:0]       valid_q,
  input logic [ENTRIES*IDX_W-1:0] ord_flat
);
  logic [ENTRIES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < ENTRIES; k++)
      seen |= ENTRIES'(1) << ord_flat[k*IDX_W +: IDX_W];
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lk_hit && lk_miss)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |-> (!lk_hit && !lk_miss)); // R1
  AST_NC_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) lk_nc |-> lk_hit); // R3
  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_match)); // R4
  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !clr_all) |=> valid_q[$past(wr_idx)]); // R4
  AST_MRU_FRONT: assert property (@(posedge clk) disable iff (!rst_n) touch_en |=> ord_flat[IDX_W-1:0] == $past(touch_idx)); // R5
  AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n) seen == '1); // R5
  AST_INV_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (inv_one && !clr_all && !wr_en) |=> (valid_q & $past(inv_match)) == '0); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n) clr_all |=> valid_q == '0); // R7
endmodule

bind xlat_buf xlat_buf_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_nc(lk_nc), .lk_match(lk_match), .clr_all(clr_all), .wr_en(wr_en), .wr_idx(wr_idx),
  .inv_one(inv_one), .inv_match(inv_match), .touch_en(touch_en), .touch_idx(touch_idx),
  .valid_q(valid_q), .ord_flat(ord_flat)
);

// File: tb/test_xlat_buf.sv
`timescale 1ns/1ps
module test_xlat_buf;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pg_sel = 2'b00;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_miss, lk_nc;
  logic [31:0] lk_pa;
  logic        wr_en = 1'b0, wr_nc = 1'b0, inv_one = 1'b0, inv_all = 1'b0;
  logic [31:0] wr_va = '0, wr_pa = '0, inv_va = '0;

  xlat_buf #(.ENTRIES(N)) i_xlat_buf (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, stamp = 0;
  bit done = 0;
  bit          m_v [N];
  logic [31:0] m_va [N], m_pa [N];
  bit          m_nc [N];
  int          m_st [N];

  function automatic int unsigned psize(logic [1:0] s);
    return (s == 2'b01) ? 1024 : (s == 2'b10) ? 2048 : 512;
  endfunction

  function automatic int find(logic [31:0] va);
    logic [31:0] base = va & ~(psize(pg_sel) - 1);
    for (int i = 0; i < N; i++)
      if (m_v[i] && ((m_va[i] & ~(psize(pg_sel) - 1)) == base)) return i;
    return -1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // lookup; expected values from the timestamp model
  task automatic look(logic [31:0] va, string req);
    int e;
    logic [31:0] sz;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    #2;
    e = find(va);
    sz = psize(pg_sel);
    chk(req, "hit", 32'(lk_hit), 32'(e >= 0));
    chk(req, "miss", 32'(lk_miss), 32'(e < 0));
    chk("R3", "nc", 32'(lk_nc), (e >= 0) ? 32'(m_nc[e]) : 32'd0);
    if (e >= 0) chk("R2", "pa", lk_pa, (m_pa[e] & ~(sz - 1)) | (va & (sz - 1)));
    @(posedge clk); #1;
    lk_valid = 1'b0;
    if (e >= 0) m_st[e] = ++stamp;
  endtask

  task automatic install(logic [31:0] va, logic [31:0] pa, bit nc);
    int e, best;
    @(negedge clk);
    wr_en = 1'b1; wr_va = va; wr_pa = pa; wr_nc = nc;
    e = find(va);
    if (e < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) e = i;
    if (e < 0) begin
      best = 0;
      for (int i = 1; i < N; i++) if (m_st[i] < m_st[best]) best = i;
      e = best;
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_v[e] = 1; m_va[e] = va; m_pa[e] = pa; m_nc[e] = nc; m_st[e] = ++stamp;
  endtask

  task automatic kill_one(logic [31:0] va);
    int e;
    @(negedge clk);
    inv_one = 1'b1; inv_va = va;
    e = find(va);
    @(posedge clk); #1;
    inv_one = 1'b0;
    if (e >= 0) m_v[e] = 0;
  endtask

  task automatic kill_all(bit with_wr);
    @(negedge clk);
    inv_all = 1'b1; wr_en = with_wr; wr_va = 32'h7777_7000; wr_pa = 32'h1234_5000;
    @(posedge clk); #1;
    inv_all = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  // change page size; lookup of a stored page in the change cycle must miss
  task automatic new_size(logic [1:0] s, logic [31:0] probe);
    @(negedge clk);
    pg_sel = s; lk_valid = 1'b1; lk_va = probe;
    #2;
    chk("R8", "hit in change cycle", 32'(lk_hit), 32'd0);
    chk("R8", "miss in change cycle", 32'(lk_miss), 32'd1);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  function automatic logic [31:0] vpage(int e);
    return (32'(e) * 32'h0012_3000) ^ 32'h4000_0000;
  endfunction
  function automatic logic [31:0] ppage(int e);
    return 32'h8000_0000 + 32'(e) * 32'h0000_5800 + 32'(e * 7);
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_st[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R9", "idle hit", 32'(lk_hit), 32'd0);
    chk("R1", "idle miss", 32'(lk_miss), 32'd0);
    for (int e = 0; e < 4; e++) look(vpage(e), "R9");

    for (int s = 0; s < 4; s++) begin
      logic [31:0] sz;
      if (s == 0) kill_all(1'b0);
      else        new_size(2'(s), vpage(0));
      sz = psize(2'(s));
      look(vpage(0), "R8");
      for (int e = 0; e < N; e++) install(vpage(e) + 32'(e * 17), ppage(e), e[0]);
      for (int e = 0; e < N; e++) begin
        look(vpage(e), "R1");
        look(vpage(e) + sz - 1, "R2");
        look(vpage(e) + 32'((e * 13) % sz), "R2");
        look(vpage(e) + sz, "R1");
      end
      // buffer full: touch some, then evict the oldest
      look(vpage(2), "R5");
      look(vpage(9), "R5");
      install(vpage(16), ppage(16), 1'b1);
      for (int e = 0; e < 17; e++) look(vpage(e), "R5");
      // freed slot is reused before the LRU entry
      kill_one(vpage(5) + 32'd3);
      look(vpage(5), "R6");
      look(vpage(6), "R6");
      install(vpage(17), ppage(17), 1'b0);
      for (int e = 0; e < 18; e++) look(vpage(e), "R4");
      // covered page is overwritten in place
      install(vpage(9) + 32'd1, 32'h0ABC_D000, 1'b1);
      look(vpage(9) + 32'd2, "R4");
      for (int e = 0; e < 18; e++) look(vpage(e), "R4");
      // flush, with an install in the same cycle that must be dropped
      kill_all(s[0]);
      look(vpage(1), "R7");
      look(32'h7777_7000, "R7");
      for (int e = 0; e < 3; e++) install(vpage(e), ppage(e), 1'b1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule